// File: doc/BRIEF.md
# Segmented DAC Switch-Control Decoder

This block sits between the digital sample stream and the switch array of a 10-bit current-steering converter. The converter is split 5+5. The five low bits drive binary-weighted cells of 1, 2, 4, 8 and 16 units directly. The five high bits select how many of 31 equal 32-unit cells conduct.

The unary cells sit in a 4-row by 8-column matrix. A column thermometer decoder takes the top three bits and a row thermometer decoder takes the next two. A small AND-OR gate at each cell merges the two. A cell turns on when the column to its right is active, or when its own column and its own row are both active.

An input register captures the word on a rising edge. An output retiming register then launches every unary enable and every binary control on one common edge. The binary bits travel through the same number of registers as the decoded enables, so both halves stay aligned. Each switch control also comes with its complement.

Top module: `segdac_switch_ctrl`

## Requirements
- R1: While `rst_n` is low, every enable output (`unary_en_o`, `bin_en_o`) is 0 and every complement output is all ones. This holds immediately after an asynchronous assertion of reset.
- R2: `bin_en_o` equals bits [4:0] of the code that was sampled two rising edges earlier.
- R3: The number of ones in `unary_en_o` equals the value of bits [9:5] of the code sampled two rising edges earlier, from 0 to 31.
- R4: Column decoding follows a threshold on bits [9:7]: column j is active when that 3-bit value is at least j, so column 0 is always active. Row decoding follows a threshold on bits [6:5]: row i is active when that 2-bit value is greater than i, so row 3 is never active.
- R5: Cell index k = row*8 + column, with row = k/8 and column = k%8, for k from 0 to 30. `unary_en_o[k]` is 1 exactly when 4*column + row is less than bits [9:5]. Equivalently, the cell is on when column+1 is active, or when its column and its row are both active.
- R6: `unary_en_n_o` is the bitwise inverse of `unary_en_o`, and `bin_en_n_o` is the bitwise inverse of `bin_en_o`, in every cycle.
- R7: Both paths have exactly two cycles of latency. After the input changes, the first rising edge still shows the previous word's controls, and the second rising edge shows the new word's controls.
- R8: When bits [9:5] rise by one, exactly one additional unary enable turns on and no enable turns off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| code_i | input | 10 | Converter input word; bits [4:0] binary part, bits [9:5] unary part |
| unary_en_o | output | 31 | Unary cell enables, index row*8+column |
| unary_en_n_o | output | 31 | Complement of the unary enables |
| bin_en_o | output | 5 | Binary cell controls, bit n weight 2^n units |
| bin_en_n_o | output | 5 | Complement of the binary controls |

## Verification
The assertions watch the following on every cycle:
- the count of unary enables against the registered high bits from the previous cycle;
- the alignment of the binary controls with the registered low bits;
- the ordering of both thermometer codes;
- the fill order of the matrix, in which no cell may be on while an earlier cell in the fill sequence is off;
- the cleared state of the registers while reset is held.

The bench scenarios show what a single cycle cannot:
- the exact cell pattern for each of the 1024 codes;
- the two-edge latency seen at the ports, using back-to-back words;
- the growth of exactly one cell at each step of the high bits;
- the response to a reset asserted in the middle of a stream.

// File: rtl/segdac_pkg.sv
package segdac_pkg;

  localparam int unsigned SEG_BIN_W = 5;
  localparam int unsigned SEG_ROW_W = 2;
  localparam int unsigned SEG_COL_W = 3;

  // Position f in the fill sequence (column by column, rows bottom-up)
  // mapped onto the physical cell index row*ncol+col.
  function automatic int unsigned fill_to_cell(input int unsigned f,
                                               input int unsigned nrow,
                                               input int unsigned ncol);
    return (f % nrow) * ncol + (f / nrow);
  endfunction

endpackage

// File: rtl/segdac_therm_dec.sv
module segdac_therm_dec #(
  parameter int unsigned IN_W      = 3,
  parameter bit          INCLUSIVE = 1'b1,
  localparam int unsigned OUT_N    = 1 << IN_W
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_N-1:0] therm_o
);

  // INCLUSIVE: bit k set when val >= k; otherwise set when val > k.
  for (genvar k = 0; k < OUT_N; k++) begin : g_bit
    if (INCLUSIVE) begin : g_ge
      if (k == 0) begin : g_one
        assign therm_o[k] = 1'b1;
      end else begin : g_cmp
        assign therm_o[k] = (val_i >= IN_W'(k));
      end
    end else begin : g_gt
      if (k == OUT_N - 1) begin : g_zero
        assign therm_o[k] = 1'b0;
      end else begin : g_cmp
        assign therm_o[k] = (val_i > IN_W'(k));
      end
    end
  end

  always_comb begin
    for (int k = 0; k < OUT_N - 1; k++) begin
      AST_THERM_ORDER: assert (!therm_o[k+1] || therm_o[k])
        else $error("thermometer bit %0d set above a clear bit", k+1); // R4
    end
  end

endmodule

// File: rtl/segdac_local_dec.sv
module segdac_local_dec
  import segdac_pkg::*;
#(
  parameter int unsigned NROW  = 4,
  parameter int unsigned NCOL  = 8,
  localparam int unsigned NCELL = NROW * NCOL - 1
) (
  input  logic [NROW-1:0]  row_i,
  input  logic [NCOL-1:0]  col_i,
  output logic [NCELL-1:0] en_o
);

  logic [NCOL:0] col_ext;
  assign col_ext = {1'b0, col_i};

  for (genvar r = 0; r < NROW; r++) begin : g_row
    for (genvar c = 0; c < NCOL; c++) begin : g_col
      if (r * NCOL + c < NCELL) begin : g_cell
        assign en_o[r*NCOL+c] = col_ext[c+1] | (col_ext[c] & row_i[r]);
      end
    end
  end

  always_comb begin
    for (int unsigned f = 0; f + 2 < NROW * NCOL; f++) begin
      AST_FILL_ORDER: assert (!en_o[fill_to_cell(f+1, NROW, NCOL)] ||
                              en_o[fill_to_cell(f, NROW, NCOL)])
        else $error("cell at fill step %0d on while step %0d off", f+1, f); // R8
    end
  end

endmodule

// File: rtl/segdac_retime.sv
module segdac_retime #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_nxt;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (q_o == '0)
        else $error("register not cleared under reset"); // R1
    end
  end

endmodule

// File: rtl/segdac_switch_ctrl.sv
module segdac_switch_ctrl
  import segdac_pkg::*;
#(
  parameter int unsigned BIN_W = SEG_BIN_W,
  parameter int unsigned ROW_W = SEG_ROW_W,
  parameter int unsigned COL_W = SEG_COL_W,
  localparam int unsigned DATA_W = BIN_W + ROW_W + COL_W,
  localparam int unsigned NROW   = 1 << ROW_W,
  localparam int unsigned NCOL   = 1 << COL_W,
  localparam int unsigned NCELL  = NROW * NCOL - 1,
  localparam int unsigned OUT_W  = NCELL + BIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] code_i,
  output logic [NCELL-1:0]  unary_en_o,
  output logic [NCELL-1:0]  unary_en_n_o,
  output logic [BIN_W-1:0]  bin_en_o,
  output logic [BIN_W-1:0]  bin_en_n_o
);

  logic [DATA_W-1:0] code_q;
  logic [BIN_W-1:0]  bin_fld;
  logic [ROW_W-1:0]  row_fld;
  logic [COL_W-1:0]  col_fld;
  logic [NROW-1:0]   row_therm;
  logic [NCOL-1:0]   col_therm;
  logic [NCELL-1:0]  cell_dec;
  logic [OUT_W-1:0]  out_d;
  logic [OUT_W-1:0]  out_q;

  // Input capture
  segdac_retime #(.W(DATA_W)) u_in_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (code_i),
    .q_o   (code_q)
  );

  assign bin_fld = code_q[BIN_W-1:0];
  assign row_fld = code_q[BIN_W +: ROW_W];
  assign col_fld = code_q[BIN_W+ROW_W +: COL_W];

  segdac_therm_dec #(.IN_W(COL_W), .INCLUSIVE(1'b1)) u_col_dec (
    .val_i   (col_fld),
    .therm_o (col_therm)
  );

  segdac_therm_dec #(.IN_W(ROW_W), .INCLUSIVE(1'b0)) u_row_dec (
    .val_i   (row_fld),
    .therm_o (row_therm)
  );

  segdac_local_dec #(.NROW(NROW), .NCOL(NCOL)) u_cells (
    .row_i (row_therm),
    .col_i (col_therm),
    .en_o  (cell_dec)
  );

  // Binary bits share the retiming register with the decoded enables,
  // giving them the same register count as the unary path.
  assign out_d = {cell_dec, bin_fld};

  segdac_retime #(.W(OUT_W)) u_out_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (out_d),
    .q_o   (out_q)
  );

  assign unary_en_o   = out_q[OUT_W-1:BIN_W];
  assign bin_en_o     = out_q[BIN_W-1:0];
  assign unary_en_n_o = ~out_q[OUT_W-1:BIN_W];
  assign bin_en_n_o   = ~out_q[BIN_W-1:0];

  AST_UNARY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(unary_en_o) == int'($past(code_q[DATA_W-1:BIN_W])))
    else $error("unary enable count differs from registered code"); // R3

  AST_BIN_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    bin_en_o == $past(code_q[BIN_W-1:0]))
    else $error("binary controls not aligned with unary path"); // R2

endmodule

// File: tb/segdac_switch_ctrl_tb.sv
`timescale 1ns/1ps
module segdac_switch_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  code_i;
  logic [30:0] unary_en_o, unary_en_n_o;
  logic [4:0]  bin_en_o, bin_en_n_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  segdac_switch_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .code_i       (code_i),
    .unary_en_o   (unary_en_o),
    .unary_en_n_o (unary_en_n_o),
    .bin_en_o     (bin_en_o),
    .bin_en_n_o   (bin_en_n_o)
  );

  // Vector table: {code, expected cell count, expected binary bits}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {10'd0,    5'd0,  5'd0},
    {10'd1023, 5'd31, 5'd31},
    {10'd32,   5'd1,  5'd0},
    {10'd31,   5'd0,  5'd31},
    {10'd992,  5'd31, 5'd0},
    {10'd96,   5'd3,  5'd0},
    {10'd128,  5'd4,  5'd0},
    {10'd160,  5'd5,  5'd0},
    {10'd544,  5'd17, 5'd0},
    {10'd661,  5'd20, 5'd21},
    {10'd255,  5'd7,  5'd31},
    {10'd768,  5'd24, 5'd0}
  };

  function automatic logic [30:0] model_unary(input logic [4:0] v);
    logic [30:0] m;
    for (int k = 0; k < 31; k++) begin
      m[k] = ((k % 8) * 4 + (k / 8)) < int'(v);
    end
    return m;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_code(input logic [9:0] c);
    logic [30:0] eu;
    eu = model_unary(c[9:5]);
    chk(unary_en_o == eu, "R5/R4 cell pattern", {1'b0, unary_en_o}, {1'b0, eu});
    chk($countones(unary_en_o) == int'(c[9:5]), "R3 cell count",
        $countones(unary_en_o), {27'd0, c[9:5]});
    chk(bin_en_o == c[4:0], "R2 binary", {27'd0, bin_en_o}, {27'd0, c[4:0]});
    chk(unary_en_n_o == ~unary_en_o && bin_en_n_o == ~bin_en_o,
        "R6 complement", {1'b0, unary_en_n_o}, {1'b0, ~unary_en_o});
  endtask

  task automatic check_reset_state();
    chk(unary_en_o == '0 && bin_en_o == '0, "R1 enables cleared",
        {1'b0, unary_en_o}, 32'd0);
    chk(unary_en_n_o == '1 && bin_en_n_o == '1, "R1 complements set",
        {1'b0, unary_en_n_o}, 32'h7fffffff);
  endtask

  initial begin
    logic [9:0]  h1, h2;
    logic [30:0] prev_u;
    rst_n  = 1'b0;
    code_i = 10'd1023;
    // R1: outputs stay cleared while reset is held, whatever the input
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_reset_state();
    end
    @(negedge clk);
    rst_n  = 1'b1;
    code_i = 10'd0;

    // Table walk: hold each word two edges, then compare to the table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      code_i = VEC[i][19:10];
      @(negedge clk);
      @(negedge clk);
      chk($countones(unary_en_o) == int'(VEC[i][9:5]), "R3 table count",
          $countones(unary_en_o), {27'd0, VEC[i][9:5]});
      chk(bin_en_o == VEC[i][4:0], "R2 table binary",
          {27'd0, bin_en_o}, {27'd0, VEC[i][4:0]});
      check_code(VEC[i][19:10]);
    end

    // R7: explicit latency, A held then B
    @(negedge clk);
    code_i = 10'd100;
    @(negedge clk);
    @(negedge clk);
    code_i = 10'd900;
    @(negedge clk);
    chk(bin_en_o == 5'd4, "R7 one edge still old", {27'd0, bin_en_o}, 32'd4);
    chk($countones(unary_en_o) == 3, "R7 one edge old count",
        $countones(unary_en_o), 32'd3);
    @(negedge clk);
    chk(bin_en_o == 5'd4, "R7 two edges new binary", {27'd0, bin_en_o}, 32'd4);
    chk($countones(unary_en_o) == 28, "R7 two edges new count",
        $countones(unary_en_o), 32'd28);

    // Back-to-back sweep of all codes, checked every cycle (R7, R8)
    h1 = 10'd900;
    h2 = 10'd900;
    prev_u = '0;
    for (int n = 0; n < 1026; n++) begin
      @(negedge clk);
      check_code(h2);
      if (n >= 2 && h2[4:0] == 5'd0 && h2[9:5] != 5'd0) begin
        chk((unary_en_o & prev_u) == prev_u && $countones(unary_en_o ^ prev_u) == 1,
            "R8 one more cell", {1'b0, unary_en_o}, {1'b0, prev_u});
      end
      prev_u = unary_en_o;
      h2 = h1;
      h1 = (n < 1024) ? 10'(n) : 10'd1023;
      code_i = h1;
    end

    // R1: asynchronous reset mid-stream
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check_reset_state();
    @(negedge clk);
    check_reset_state();
    rst_n  = 1'b1;
    code_i = 10'd613;
    @(negedge clk);
    check_reset_state();
    @(negedge clk);
    check_code(10'd613);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule